// File: doc/BRIEF.md
# GPIO Output Blink Controller

This block sits inside a bank of 32 general-purpose I/O pins. It holds a read/write blink-enable register in the bank's register window. For each pin it combines that register with the pin's direction bit and its stored output level to produce the pad output. When a pin is driven as an output and its blink bit is set, the pad follows a slow square wave instead of the level bit. The level bit itself is never modified, so clearing the blink bit puts the pin straight back to its programmed level.

A single free-running divider derives the blink phase from the input clock. Its half period is `CLK_HZ / (2 * BLINK_HZ)` cycles, which gives a 50% duty square wave, about 1 Hz with the default parameters. Every blinking pin uses this one phase, so all of them blink in step.

The enable bits are split between two power domains by a parameter mask. Bits in the always-on domain, together with the divider, are cleared by the always-on reset or by a software full-reset strobe. The other bits are cleared only by the core reset. Bit positions named in a reserved mask hold no storage.

Top module: `gpio_blink_ctl`

## Requirements
- R1: While both resets are asserted, `reg_rdata` at the blink offset reads 0 and every pad follows `pin_level`.
- R2: A write with `reg_addr` equal to `REG_OFFSET` (default 8'h18) stores `reg_wdata` into the non-reserved bits, readable from the next cycle. A write to any other address changes nothing. A read of any other address returns 0.
- R3: Bits set in `RSVD_MASK` (default 32'hC000_0001, bits 31, 30 and 0) always read 0 and ignore writes.
- R4: A pin whose `pin_dir_out` bit is 0 (input) or whose blink bit is 0 drives `pad_out` equal to its `pin_level` bit.
- R5: A pin whose `pin_dir_out` bit is 1 and whose blink bit is 1 drives `pad_out` equal to `blink_phase`.
- R6: Clearing a blink bit returns that pad to `pin_level` on the cycle after the write. Setting or clearing it never alters `pin_level`.
- R7: `blink_phase` is 0 while the always-on reset is asserted. After release it inverts every `CLK_HZ/(2*BLINK_HZ)` rising edges, so the first inversion falls on the edge with that number.
- R8: Asserting `core_rst_n` low clears at once every enable bit outside `RESUME_MASK` and leaves the bits inside it unchanged.
- R9: Asserting `resume_rst_n` low clears at once every enable bit inside `RESUME_MASK` and leaves the other bits unchanged.
- R10: `soft_full_rst` high at a clock edge clears the bits inside `RESUME_MASK` at that edge, even if a write to those bits happens on the same edge. Bits outside the mask still take that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Asynchronous active-low core-domain reset |
| resume_rst_n | input | 1 | Asynchronous active-low always-on-domain reset (also resets the divider) |
| soft_full_rst | input | 1 | Synchronous software full-reset strobe for always-on bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset within the GPIO window |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data, combinational from `reg_addr` |
| pin_dir_out | input | W | Per-pin direction, 1 = output |
| pin_level | input | W | Per-pin stored output level |
| pad_out | output | W | Per-pin pad output value |
| blink_phase | output | 1 | Shared blink square wave |

## Verification
A register write is seen on `reg_rdata` and on `pad_out` one rising edge after the cycle that carries it. The soft strobe behaves the same way. Changes to direction or level, and asserted asynchronous resets, appear without waiting for an edge. The driver applies each stimulus on a falling edge and queues the item it expects. The monitor pops that item one time unit after the next rising edge and compares it against a phase model that counts edges since the always-on reset, so every result is sampled at its due cycle.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

  typedef enum logic {
    DOM_CORE   = 1'b0,
    DOM_RESUME = 1'b1
  } blink_domain_e;

  // Edges per half wave of the blink square wave, never below 2.
  function automatic int unsigned half_period(input int unsigned clk_hz,
                                              input int unsigned blink_hz);
    int unsigned h;
    h = clk_hz / (2 * blink_hz);
    return (h < 2) ? 2 : h;
  endfunction

  // One pad: the shared phase while blinking, the level bit otherwise.
  function automatic logic pad_bit(input logic is_out, input logic blink_en,
                                   input logic level, input logic phase);
    return (is_out && blink_en) ? phase : level;
  endfunction

  // Storage mask of one domain after reserved positions are removed.
  function automatic logic [31:0] domain_mask(input blink_domain_e dom,
                                              input logic [31:0] resume_mask,
                                              input logic [31:0] rsvd_mask);
    return (dom == DOM_RESUME) ? (resume_mask & ~rsvd_mask)
                               : (~resume_mask & ~rsvd_mask);
  endfunction

endpackage

// File: rtl/blink_timebase.sv
module blink_timebase #(
  parameter int unsigned HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase,
  output logic wrap
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R7: the phase inverts exactly on the wrap edge and holds in between
  a_r7_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (phase != $past(phase)));
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(phase));
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/blink_domain_bank.sv
module blink_domain_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '0,
  parameter bit SOFT_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] bits
);
  logic clr;

  generate
    if (SOFT_CLR) begin : g_soft
      assign clr = soft_clr;
    end else begin : g_nosoft
      assign clr = 1'b0 & soft_clr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits <= '0;
    else if (clr)    bits <= '0;
    else if (wr_hit) bits <= wdata & MASK;
  end

  // R2: a write lands in this domain's bits on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !clr) |=> (bits == ($past(wdata) & MASK)));
  // R2: without a write or clear the bits hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !clr) |=> $stable(bits));
  // R10: the soft strobe wins over a same-edge write
  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bits == '0));

endmodule

// File: rtl/blink_pad_mux.sv
module blink_pad_mux
  import gpio_blink_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dir_out,
  input  logic [W-1:0] blink_en,
  input  logic [W-1:0] level,
  input  logic         phase,
  output logic [W-1:0] active,
  output logic [W-1:0] pad
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign active[i] = dir_out[i] & blink_en[i];
      assign pad[i]    = pad_bit(dir_out[i], blink_en[i], level[i], phase);
    end
  endgenerate
endmodule

// File: rtl/gpio_blink_ctl.sv
module gpio_blink_ctl
  import gpio_blink_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 250_000_000,
  parameter int unsigned BLINK_HZ    = 1,
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  REG_OFFSET  = 8'h18,
  parameter logic [31:0] RESUME_MASK = 32'h0F00_FF00,
  parameter logic [31:0] RSVD_MASK   = 32'hC000_0001
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              resume_rst_n,
  input  logic              soft_full_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       pin_dir_out,
  input  logic [31:0]       pin_level,
  output logic [31:0]       pad_out,
  output logic              blink_phase
);
  localparam int unsigned W    = 32;
  localparam int unsigned HALF = half_period(CLK_HZ, BLINK_HZ);
  localparam logic [W-1:0] RES_BITS  = domain_mask(DOM_RESUME, RESUME_MASK, RSVD_MASK);
  localparam logic [W-1:0] CORE_BITS = domain_mask(DOM_CORE, RESUME_MASK, RSVD_MASK);

  logic         addr_hit;
  logic         wr_hit;
  logic         tb_wrap;
  logic [W-1:0] dom_bits [2];
  logic [W-1:0] blink_en;
  logic [W-1:0] blink_active;

  assign addr_hit = (reg_addr == ADDR_W'(REG_OFFSET));
  assign wr_hit   = reg_wr & addr_hit;

  blink_timebase #(.HALF(HALF)) u_tb (
    .clk  (clk),
    .rst_n(resume_rst_n),
    .phase(blink_phase),
    .wrap (tb_wrap)
  );

  generate
    for (genvar d = 0; d < 2; d++) begin : g_dom
      localparam logic [W-1:0] DMASK = (d == 1) ? RES_BITS : CORE_BITS;
      logic dom_rst_n;
      assign dom_rst_n = (d == 1) ? resume_rst_n : core_rst_n;
      blink_domain_bank #(.W(W), .MASK(DMASK), .SOFT_CLR(d == 1)) u_bank (
        .clk     (clk),
        .rst_n   (dom_rst_n),
        .soft_clr(soft_full_rst),
        .wr_hit  (wr_hit),
        .wdata   (reg_wdata),
        .bits    (dom_bits[d])
      );
    end
  endgenerate

  assign blink_en  = dom_bits[0] | dom_bits[1];
  assign reg_rdata = addr_hit ? blink_en : '0;

  blink_pad_mux #(.W(W)) u_mux (
    .dir_out(pin_dir_out),
    .blink_en(blink_en),
    .level  (pin_level),
    .phase  (blink_phase),
    .active (blink_active),
    .pad    (pad_out)
  );

  // R3: reserved positions never read back as 1
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!core_rst_n || !resume_rst_n)
    (reg_rdata & RSVD_MASK) == '0);
  // R5: every blinking pad carries the timebase phase
  a_r5_blink_follows_phase: assert property (@(posedge clk) disable iff (!core_rst_n || !resume_rst_n)
    (pad_out & blink_active) == ({W{blink_phase}} & blink_active));
  // R4: every non-blinking pad carries its level bit
  a_r4_idle_follows_level: assert property (@(posedge clk) disable iff (!core_rst_n || !resume_rst_n)
    (pad_out & ~blink_active) == (pin_level & ~blink_active));
  // R8: a held core reset keeps the core-domain bits clear
  a_r8_core_bits_clear: assert property (@(posedge clk) disable iff (!resume_rst_n)
    !core_rst_n |-> ((blink_en & CORE_BITS) == '0));
  // R6: a write that clears all blink bits leaves every pad on its level
  a_r6_clear_returns_level: assert property (@(posedge clk) disable iff (!core_rst_n || !resume_rst_n)
    (wr_hit && reg_wdata == '0) |=> (pad_out == pin_level));

endmodule

// File: tb/gpio_blink_ctl_test.sv
`timescale 1ns/1ps
module gpio_blink_ctl_test;
  localparam int unsigned CLK_HZ = 16;
  localparam int unsigned HALF   = 8;
  localparam logic [7:0]  OFF    = 8'h18;
  localparam logic [31:0] RESM   = 32'h0F00_FF00;
  localparam logic [31:0] RSVD   = 32'hC000_0001;
  localparam logic [31:0] RBITS  = RESM & ~RSVD;
  localparam logic [31:0] CBITS  = ~RESM & ~RSVD;

  logic clk = 1'b0;
  logic core_rst_n = 1'b0, resume_rst_n = 1'b0, soft_full_rst = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0]  reg_addr = OFF;
  logic [31:0] reg_wdata = '0, pin_dir_out = '0, pin_level = '0;
  logic [31:0] reg_rdata, pad_out;
  logic        blink_phase;

  always #2 clk = ~clk;

  gpio_blink_ctl #(.CLK_HZ(CLK_HZ), .BLINK_HZ(1), .ADDR_W(8), .REG_OFFSET(OFF),
                   .RESUME_MASK(RESM), .RSVD_MASK(RSVD)) uut (
    .clk(clk), .core_rst_n(core_rst_n), .resume_rst_n(resume_rst_n),
    .soft_full_rst(soft_full_rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_dir_out(pin_dir_out),
    .pin_level(pin_level), .pad_out(pad_out), .blink_phase(blink_phase));

  typedef struct {
    logic [31:0] en;
    logic [31:0] rd;
    string       req;
  } item_t;

  item_t       q[$];
  int          n_chk = 0, n_bad = 0;
  logic [31:0] model_en = '0;
  int          m_cnt = 0;
  logic        m_ph = 1'b0;
  bit          done = 1'b0;

  // Phase model from R7: invert every HALF edges since the always-on reset
  always @(posedge clk or negedge resume_rst_n) begin
    if (!resume_rst_n) begin
      m_cnt <= 0; m_ph <= 1'b0;
    end else if (m_cnt == HALF - 1) begin
      m_cnt <= 0; m_ph <= ~m_ph;
    end else m_cnt <= m_cnt + 1;
  end

  // Monitor: one queued item is due one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act, exp_pad;
      it = q.pop_front();
      act = pin_dir_out & it.en;
      exp_pad = (act & {32{m_ph}}) | (~act & pin_level);
      n_chk++;
      if (reg_rdata !== it.rd || pad_out !== exp_pad || blink_phase !== m_ph) begin
        n_bad++;
        $display("FAIL %s: rdata=%h pad=%h phase=%b expected rdata=%h pad=%h phase=%b",
                 it.req, reg_rdata, pad_out, blink_phase, it.rd, exp_pad, m_ph);
      end
    end
  end

  task automatic step(input string req);
    item_t it;
    it.en = model_en;
    it.rd = (reg_addr == OFF) ? model_en : '0;
    it.req = req;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == OFF) model_en = d & ~RSVD;
    step(req);
    reg_wr = 1'b0; reg_addr = OFF;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    pin_level = 32'hA5A5_5A5A; pin_dir_out = 32'hFFFF_FFFF;
    step("R1 reset value"); step("R1 reset value");
    resume_rst_n = 1'b1; core_rst_n = 1'b1;
    step("R1 after release");
    // R2/R3: write ones, reserved bits read 0; inputs keep level (R4)
    pin_dir_out = '0;
    wr(OFF, 32'hFFFF_FFFF, "R3 reserved bits read 0");
    step("R2 readback");
    step("R4 inputs ignore blink");
    // R5/R7: mixed directions blink in step, counted for several half waves
    wr(OFF, 32'h0F0F_F0F0, "R2 pattern write");
    pin_dir_out = 32'hFFFF_0000; pin_level = 32'h1234_5678;
    for (int i = 0; i < 3 * HALF + 3; i++) step("R5 R7 blink phase");
    // R2: other offset neither reads nor writes
    wr(8'h1C, 32'hFFFF_FFFF, "R2 other offset ignored");
    reg_addr = 8'h1C; step("R2 other offset reads 0"); reg_addr = OFF;
    step("R2 value kept");
    // R6: clearing returns pads to level
    pin_dir_out = 32'hFFFF_FFFF;
    wr(OFF, 32'hFFFF_FFFE, "R5 all blinking");
    for (int i = 0; i < HALF; i++) step("R5 all blinking");
    wr(OFF, 32'h0000_0000, "R6 clear returns level");
    step("R6 level unchanged");
    // R8: core reset clears only core bits
    wr(OFF, 32'hFFFF_FFFF, "R2 fill");
    core_rst_n = 1'b0; model_en = model_en & RBITS;
    step("R8 core reset keeps resume bits");
    core_rst_n = 1'b1;
    step("R8 after core reset");
    // R9: always-on reset clears only its bits and the phase
    wr(OFF, 32'hFFFF_FFFF, "R2 fill");
    resume_rst_n = 1'b0; model_en = model_en & CBITS;
    step("R9 resume reset keeps core bits");
    resume_rst_n = 1'b1;
    for (int i = 0; i < HALF + 2; i++) step("R7 phase restart");
    // R10: soft strobe beats same-edge write for always-on bits
    wr(OFF, 32'h0000_0000, "R2 clear");
    soft_full_rst = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    model_en = 32'hFFFF_FFFF & CBITS;
    step("R10 soft clear wins");
    soft_full_rst = 1'b0; reg_wr = 1'b0;
    wr(OFF, RBITS, "R2 refill resume bits");
    soft_full_rst = 1'b1; model_en = '0;
    step("R10 soft clear alone");
    soft_full_rst = 1'b0;
    step("R10 held");
    @(posedge clk); #2;
    done = 1'b1;
    finish_run();
  end
endmodule